// File: doc/BRIEF.md
# Register-Write Command Executor

This block runs a queue of register-programming instructions that software has placed in memory. After it is switched on and given a start address and an end address, it reads the queue one 32-bit word at a time through a single-outstanding request/response memory port. It decodes the words as 8-byte instructions and issues the register writes they describe on a write-only register port. Each write carries a 20-bit register offset, 32 bits of data and 4 byte enables.

Each instruction is a pair of words. The first word is the operand. The second word holds the operation code in bits [31:24], byte enables in [23:20] and the register offset in [19:0]. A plain write sends the operand to the offset. An indexed write takes the operand as a count N and then streams the N following words to one offset. When N is odd, one filler word follows the data so that the next pair stays 8-byte aligned. The remaining defined codes are consumed as two-word no-ops. Execution can be held back until the next vertical blanking pulse. It can also be cancelled at any time by switching the block off.

Top module: `regwr_cmd_engine`

## Requirements
- R1: After reset, `busy`, `mem_req` and `reg_we` are all low.
- R2: For an instruction with code 0x01 in bits [31:24] of its second word, the block makes one register write. The offset comes from bits [19:0] of the second word, the byte enables from bits [23:20] of the second word, and the data is the first word.
- R3: For code 0x09, the first word is a count N. The N words that follow are written, in memory order, to the offset in bits [19:0] of the second word, each with all four byte enables set.
- R4: After an indexed write with odd N, the single word that follows the data is skipped unread as an instruction. With even N no word is skipped.
- R5: An indexed write with N = 0 makes no write, and the next word pair is the next instruction.
- R6: The codes 0x00, 0x02 to 0x07 and 0x0A make no write and take exactly two words.
- R7: Words are fetched one at a time, in ascending order by 4, from the start address up to but not including the end address. `busy` rises on the enabling write and stays high until every word up to the end address has been fetched and consumed. It then falls.
- R8: Bits [5:0] of the written end address are ignored, so the end is always a 64-byte boundary. Bits [2:0] of the start address are ignored.
- R9: When bit 1 of the control word is set together with enable, no fetch happens after the end-address write until a `vblank_pulse` arrives.
- R10: Writing the control word with bit 0 clear while busy stops the block. `busy` is low in the next cycle, and no further `mem_req` or `reg_we` occurs.
- R11: Configuration selects are 0 for control (bit 0 enable, bit 1 wait-for-vblank), 1 for start address and 2 for end address. Fetching begins only on the end-address write that follows an enable, so an enabled block with only a start address written stays quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 control, 1 start address, 2 end address |
| cfg_wdata | input | 32 | Configuration write data |
| vblank_pulse | input | 1 | One-cycle vertical blanking pulse |
| busy | output | 1 | High while a queue is armed or running |
| mem_req | output | 1 | Memory read request, one cycle per word |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Memory response word |
| reg_we | output | 1 | Register write strobe |
| reg_offset | output | 20 | Register offset |
| reg_wdata | output | 32 | Register write data |
| reg_be | output | 4 | Register byte enables |

## Verification
The hardest case to reach from the ports is the filler word after an odd-length indexed write. If it were decoded instead of skipped, the stream would quietly lose its pairing, and later instructions would look plausible but be wrong. The stimulus fills that slot with an all-ones word and places plain writes right after odd, even and zero-length indexed writes. The scoreboard then shows any loss of alignment as a mismatched offset, value or byte-enable. Cancellation is driven while words are still in flight, after the first write has appeared, so a response that arrives late must be dropped.

// File: rtl/regwr_pkg.sv
package regwr_pkg;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_TAIL = 2'd2;

  localparam logic [7:0] OP_SINGLE  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  typedef enum logic [1:0] {
    C_IDLE   = 2'd0,
    C_ARMED  = 2'd1,
    C_VBWAIT = 2'd2,
    C_RUN    = 2'd3
  } ctl_state_e;

  typedef enum logic [1:0] {
    D_LO   = 2'd0,
    D_HI   = 2'd1,
    D_DATA = 2'd2,
    D_PAD  = 2'd3
  } dec_state_e;

endpackage

// File: rtl/regwr_ctl.sv
module regwr_ctl
  import regwr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          vblank_pulse,
  input  logic          fetch_done,
  output logic          run,
  output logic          busy,
  output logic          start,
  output logic          abort,
  output logic [AW-1:0] head_addr,
  output logic [AW-1:0] tail_addr
);

  localparam int LINE_LSB = $clog2(LINE_BYTES);

  ctl_state_e    st_q, st_d;
  logic          vb_q, vb_d;
  logic [AW-1:0] head_q, head_d;
  logic [AW-1:0] tail_q, tail_d;

  logic wr_ctrl, wr_head, wr_tail, can_cfg;

  assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
  assign wr_head = cfg_we && (cfg_sel == SEL_HEAD);
  assign wr_tail = cfg_we && (cfg_sel == SEL_TAIL);
  assign can_cfg = (st_q == C_IDLE) || (st_q == C_ARMED);

  always_comb begin
    st_d   = st_q;
    vb_d   = vb_q;
    head_d = head_q;
    tail_d = tail_q;
    start  = 1'b0;
    abort  = 1'b0;
    if (wr_ctrl && !cfg_wdata[0] && (st_q != C_IDLE)) begin
      abort = 1'b1;
      st_d  = C_IDLE;
    end else begin
      case (st_q)
        C_IDLE: begin
          if (wr_ctrl && cfg_wdata[0]) begin
            st_d = C_ARMED;
            vb_d = cfg_wdata[1];
          end
        end
        C_ARMED: begin
          if (wr_tail) begin
            if (vb_q) begin
              st_d = C_VBWAIT;
            end else begin
              st_d  = C_RUN;
              start = 1'b1;
            end
          end
        end
        C_VBWAIT: begin
          if (vblank_pulse) begin
            st_d  = C_RUN;
            start = 1'b1;
          end
        end
        default: begin
          if (fetch_done) st_d = C_IDLE;
        end
      endcase
    end
    if (can_cfg && wr_head) head_d = {cfg_wdata[AW-1:3], 3'b000};
    if (can_cfg && wr_tail) tail_d = {cfg_wdata[AW-1:LINE_LSB], {LINE_LSB{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      vb_q   <= 1'b0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      st_q   <= st_d;
      vb_q   <= vb_d;
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign run       = (st_q == C_RUN);
  assign busy      = (st_q != C_IDLE);
  assign head_addr = head_q;
  assign tail_addr = tail_q;

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  // R9
  vbwait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == C_VBWAIT && !vblank_pulse && !abort) |=> (busy && !run));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort && !(run && fetch_done)) |=> busy);

endmodule

// File: rtl/regwr_fetch.sv
module regwr_fetch #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] head_addr,
  input  logic [AW-1:0] tail_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          dw_valid,
  output logic [DW-1:0] dw_data,
  output logic          done
);

  localparam int STEP = DW / 8;

  logic [AW-1:0] ptr_q, ptr_d;
  logic          pend_q, pend_d;
  logic          at_end;

  assign at_end   = (ptr_q == tail_addr);
  assign mem_req  = run && !pend_q && !at_end;
  assign mem_addr = ptr_q;
  assign dw_valid = pend_q && mem_rvalid;
  assign dw_data  = mem_rdata;
  assign done     = run && !pend_q && at_end;

  always_comb begin
    ptr_d  = ptr_q;
    pend_d = pend_q;
    if (abort) begin
      pend_d = 1'b0;
    end else if (start) begin
      ptr_d  = head_addr;
      pend_d = 1'b0;
    end else if (dw_valid) begin
      ptr_d  = ptr_q + AW'(STEP);
      pend_d = 1'b0;
    end else if (mem_req) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
    end
  end

  // R7
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_valid && !abort && !start) |=> (mem_addr == $past(mem_addr) + AW'(STEP)));

endmodule

// File: rtl/regwr_decode.sv
module regwr_decode
  import regwr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFF_W = 20,
  parameter int BE_W  = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             dw_valid,
  input  logic [DW-1:0]    dw_data,
  output logic             reg_we,
  output logic [OFF_W-1:0] reg_offset,
  output logic [DW-1:0]    reg_wdata,
  output logic [BE_W-1:0]  reg_be
);

  localparam int OP_LSB = 24;
  localparam int BE_LSB = OFF_W;

  dec_state_e       st_q, st_d;
  logic [DW-1:0]    lo_q, lo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             odd_q, odd_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             we_q, we_d;
  logic [OFF_W-1:0] woff_q, woff_d;
  logic [DW-1:0]    wdat_q, wdat_d;
  logic [BE_W-1:0]  wbe_q, wbe_d;
  logic [7:0]       opc;

  assign opc = dw_data[OP_LSB +: 8];

  always_comb begin
    st_d   = st_q;
    lo_d   = lo_q;
    cnt_d  = cnt_q;
    odd_d  = odd_q;
    off_d  = off_q;
    we_d   = 1'b0;
    woff_d = woff_q;
    wdat_d = wdat_q;
    wbe_d  = wbe_q;
    if (clear) begin
      st_d = D_LO;
    end else if (dw_valid) begin
      case (st_q)
        D_LO: begin
          lo_d = dw_data;
          st_d = D_HI;
        end
        D_HI: begin
          st_d = D_LO;
          if (opc == OP_SINGLE) begin
            we_d   = 1'b1;
            woff_d = dw_data[OFF_W-1:0];
            wdat_d = lo_q;
            wbe_d  = dw_data[BE_LSB +: BE_W];
          end else if (opc == OP_INDEXED) begin
            off_d = dw_data[OFF_W-1:0];
            cnt_d = CNT_W'(lo_q);
            odd_d = lo_q[0];
            if (lo_q != '0) st_d = D_DATA;
          end
        end
        D_DATA: begin
          we_d   = 1'b1;
          woff_d = off_q;
          wdat_d = dw_data;
          wbe_d  = {BE_W{1'b1}};
          cnt_d  = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) st_d = odd_q ? D_PAD : D_LO;
        end
        default: begin
          st_d = D_LO;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= D_LO;
      lo_q   <= '0;
      cnt_q  <= '0;
      odd_q  <= 1'b0;
      off_q  <= '0;
      we_q   <= 1'b0;
      woff_q <= '0;
      wdat_q <= '0;
      wbe_q  <= '0;
    end else begin
      st_q   <= st_d;
      lo_q   <= lo_d;
      cnt_q  <= cnt_d;
      odd_q  <= odd_d;
      off_q  <= off_d;
      we_q   <= we_d;
      woff_q <= woff_d;
      wdat_q <= wdat_d;
      wbe_q  <= wbe_d;
    end
  end

  assign reg_we     = we_q;
  assign reg_offset = woff_q;
  assign reg_wdata  = wdat_q;
  assign reg_be     = wbe_q;

  // R4
  pad_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == D_PAD && dw_valid) |=> !reg_we);

  // R2
  write_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(dw_valid && !clear));

  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == D_HI && dw_valid && !clear && opc == OP_INDEXED && lo_q == '0)
      |=> (st_q == D_LO && !reg_we));

endmodule

// File: rtl/regwr_cmd_engine.sv
module regwr_cmd_engine
  import regwr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int OFF_W      = 20,
  parameter int BE_W       = 4,
  parameter int CNT_W      = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             vblank_pulse,
  output logic             busy,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             reg_we,
  output logic [OFF_W-1:0] reg_offset,
  output logic [DW-1:0]    reg_wdata,
  output logic [BE_W-1:0]  reg_be
);

  logic          run, start, abort, fetch_done, dw_valid;
  logic [AW-1:0] head_addr, tail_addr;
  logic [DW-1:0] dw_data;

  regwr_ctl #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .vblank_pulse (vblank_pulse),
    .fetch_done   (fetch_done),
    .run          (run),
    .busy         (busy),
    .start        (start),
    .abort        (abort),
    .head_addr    (head_addr),
    .tail_addr    (tail_addr)
  );

  regwr_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .start      (start),
    .abort      (abort),
    .head_addr  (head_addr),
    .tail_addr  (tail_addr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .dw_valid   (dw_valid),
    .dw_data    (dw_data),
    .done       (fetch_done)
  );

  regwr_decode #(.DW(DW), .OFF_W(OFF_W), .BE_W(BE_W), .CNT_W(CNT_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (abort | start),
    .dw_valid   (dw_valid),
    .dw_data    (dw_data),
    .reg_we     (reg_we),
    .reg_offset (reg_offset),
    .reg_wdata  (reg_wdata),
    .reg_be     (reg_be)
  );

  // R10
  quiet_after_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!mem_req && !reg_we));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

endmodule

// File: tb/tb_regwr_cmd_engine.sv
module tb_regwr_cmd_engine;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        vblank_pulse;
  logic        busy;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        reg_we;
  logic [19:0] reg_offset;
  logic [31:0] reg_wdata;
  logic [3:0]  reg_be;

  regwr_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .vblank_pulse(vblank_pulse), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_offset(reg_offset),
    .reg_wdata(reg_wdata), .reg_be(reg_be)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] mem [0:255];
  always_ff @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[9:2]];
  end

  int errors = 0;
  int checks = 0;
  int pops   = 0;
  int req_cnt = 0;
  int stray_cnt = 0;
  logic [31:0] exp_addr;
  logic addr_chk_en = 1'b0;
  logic [55:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard for writes, address sequence for fetches
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) begin
        stray_cnt++;
        check("R10 unexpected write", {12'h0, reg_offset, reg_wdata}, 64'h0);
      end else begin
        logic [55:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        pops++;
        check(t, {8'h0, reg_offset, reg_wdata, reg_be}, {8'h0, e});
      end
    end
    if (rst_n && mem_req) begin
      req_cnt++;
      if (addr_chk_en) begin
        check("R7 fetch address", {32'h0, mem_addr}, {32'h0, exp_addr});
        exp_addr = exp_addr + 32'd4;
      end
    end
  end

  task automatic push(input string tag, input logic [19:0] off, input logic [31:0] d, input logic [3:0] be);
    exp_q.push_back({off, d, be});
    tag_q.push_back(tag);
  endtask

  task automatic put_pair(input int idx, input logic [31:0] lo, input logic [7:0] op,
                          input logic [3:0] be, input logic [19:0] off);
    mem[idx]   = lo;
    mem[idx+1] = {op, be, off};
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  // Program 1 at word 0, end at byte 0x100
  task automatic build_prog1(input bit do_push);
    put_pair(0, 32'hAAAA_0001, 8'h01, 4'hF, 20'h12345);
    if (do_push) push("R2 write full be", 20'h12345, 32'hAAAA_0001, 4'hF);
    put_pair(2, 32'h5555_1234, 8'h01, 4'h3, 20'h00400);
    if (do_push) push("R2 write partial be", 20'h00400, 32'h5555_1234, 4'h3);
    put_pair(4, 32'hDEAD_0000, 8'h00, 4'hF, 20'h00111);
    for (int k = 0; k < 7; k++) begin
      logic [7:0] op;
      op = (k == 6) ? 8'h0A : 8'(k + 2);
      put_pair(6 + 2*k, 32'hBAD0_0000 + 32'(k), op, 4'hF, 20'h0F000 + 20'(k));
    end
    put_pair(20, 32'd3, 8'h09, 4'h0, 20'h00800);
    mem[22] = 32'h1111_0001; mem[23] = 32'h1111_0002; mem[24] = 32'h1111_0003;
    mem[25] = 32'hFFFF_FFFF;
    if (do_push) begin
      push("R3 indexed odd d0", 20'h00800, 32'h1111_0001, 4'hF);
      push("R3 indexed odd d1", 20'h00800, 32'h1111_0002, 4'hF);
      push("R3 indexed odd d2", 20'h00800, 32'h1111_0003, 4'hF);
    end
    put_pair(26, 32'h2222_0000, 8'h01, 4'hC, 20'h00A04);
    if (do_push) push("R4 write after pad", 20'h00A04, 32'h2222_0000, 4'hC);
    put_pair(28, 32'd2, 8'h09, 4'h0, 20'h00900);
    mem[30] = 32'h3333_0001; mem[31] = 32'h3333_0002;
    if (do_push) begin
      push("R3 indexed even d0", 20'h00900, 32'h3333_0001, 4'hF);
      push("R3 indexed even d1", 20'h00900, 32'h3333_0002, 4'hF);
    end
    put_pair(32, 32'h4444_0000, 8'h01, 4'h1, 20'h00B00);
    if (do_push) push("R4 write after even", 20'h00B00, 32'h4444_0000, 4'h1);
    put_pair(34, 32'd0, 8'h09, 4'h0, 20'h00A00);
    put_pair(36, 32'h5555_0000, 8'h01, 4'h8, 20'h00C00);
    if (do_push) push("R5 write after zero count", 20'h00C00, 32'h5555_0000, 4'h8);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 32'h0; vblank_pulse = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy after reset", {63'h0, busy}, 64'h0);
    check("R1 mem_req after reset", {63'h0, mem_req}, 64'h0);
    check("R1 reg_we after reset", {63'h0, reg_we}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Test 1: main stream, start gating by end-address write
    build_prog1(1'b1);
    req_cnt = 0;
    cfg_write(2'd0, 32'h1);
    check("R7 busy on enable", {63'h0, busy}, 64'h1);
    cfg_write(2'd1, 32'h0000_0000);
    repeat (10) @(negedge clk);
    check("R11 no fetch before end write", 64'(req_cnt), 64'd0);
    exp_addr = 32'h0; addr_chk_en = 1'b1;
    cfg_write(2'd2, 32'h0000_0100);
    wait_idle(2000);
    repeat (3) @(negedge clk);
    check("R7 busy falls at end", {63'h0, busy}, 64'h0);
    check("R7 word count", 64'(req_cnt), 64'd64);
    check("R6 all expected writes seen", 64'(exp_q.size()), 64'd0);

    // Test 2: end address low bits ignored, head latch with low bits
    for (int i = 128; i < 160; i++) mem[i] = 32'h0;
    put_pair(128, 32'h6666_0000, 8'h01, 4'hF, 20'h00D00);
    push("R11 write at new head", 20'h00D00, 32'h6666_0000, 4'hF);
    put_pair(144, 32'h7777_0000, 8'h01, 4'hF, 20'h00E00);
    req_cnt = 0;
    cfg_write(2'd0, 32'h1);
    cfg_write(2'd1, 32'h0000_0205);
    exp_addr = 32'h200;
    cfg_write(2'd2, 32'h0000_027C);
    wait_idle(2000);
    repeat (3) @(negedge clk);
    check("R8 words up to aligned end", 64'(req_cnt), 64'd16);
    check("R8 queue drained", 64'(exp_q.size()), 64'd0);

    // Test 3: wait for vblank
    for (int i = 192; i < 208; i++) mem[i] = 32'h0;
    put_pair(192, 32'h8888_0000, 8'h01, 4'h6, 20'h00F00);
    push("R9 write after vblank", 20'h00F00, 32'h8888_0000, 4'h6);
    req_cnt = 0;
    cfg_write(2'd0, 32'h3);
    cfg_write(2'd1, 32'h0000_0300);
    exp_addr = 32'h300;
    cfg_write(2'd2, 32'h0000_0340);
    repeat (20) @(negedge clk);
    check("R9 no fetch before vblank", 64'(req_cnt), 64'd0);
    check("R9 busy while waiting", {63'h0, busy}, 64'h1);
    vblank_pulse = 1'b1;
    @(negedge clk);
    vblank_pulse = 1'b0;
    wait_idle(2000);
    repeat (3) @(negedge clk);
    check("R9 words after vblank", 64'(req_cnt), 64'd16);
    check("R9 queue drained", 64'(exp_q.size()), 64'd0);

    // Test 4: cancel while running
    build_prog1(1'b1);
    pops = 0;
    cfg_write(2'd0, 32'h1);
    cfg_write(2'd1, 32'h0);
    addr_chk_en = 1'b0;
    cfg_write(2'd2, 32'h100);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (pops >= 1) break;
    end
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    exp_q.delete(); tag_q.delete();
    check("R10 busy low after cancel", {63'h0, busy}, 64'h0);
    req_cnt = 0; stray_cnt = 0;
    repeat (40) @(negedge clk);
    check("R10 no fetch after cancel", 64'(req_cnt), 64'd0);
    check("R10 no write after cancel", 64'(stray_cnt), 64'd0);

    // Test 5: cancel while waiting for vblank
    cfg_write(2'd0, 32'h3);
    cfg_write(2'd1, 32'h300);
    cfg_write(2'd2, 32'h340);
    cfg_write(2'd0, 32'h0);
    req_cnt = 0;
    vblank_pulse = 1'b1;
    @(negedge clk);
    vblank_pulse = 1'b0;
    repeat (20) @(negedge clk);
    check("R10 cancel before vblank busy", {63'h0, busy}, 64'h0);
    check("R10 cancel before vblank fetch", 64'(req_cnt), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule